// File: doc/BRIEF.md
# Global Memory Window Decoder

This block splits a processor's 16-bit data address space into a private local part and a shared global part at the top of the space. An 8-bit window register sits at data address 5. Its value is a run of leading ones, and it selects how much of the space is global. A value with bit 7 set picks a power-of-two region that always ends at FFFF. The smallest region is 256 words, for a value of all ones. The largest is 32,768 words, for a value with only bit 7 set. When bit 7 is clear, every address is local.

Each data access presents an address, a strobe, a read/write flag and write data. The block compares the address high byte with the window register. For an access that falls in the global window, it drives an active-low bus request in the same cycle as the strobe. It also raises a stall output until the external arbiter answers with ready. Local accesses never request the bus and never wait. Reads of address 5 return the register in the low byte, and the upper byte reads as ones.

Top module: `gwin_decoder`

## Requirements
- R1: After a synchronous active-low reset, the window register is 0. No address is then global, and `breq_n` stays high.
- R2: A strobed write (`strb`=1, `wr`=1) to address 16'h0005 loads `wdata[7:0]` into the window register at that clock edge. The write completes in one cycle, like any local write.
- R3: A strobed read (`strb`=1, `wr`=0) of address 16'h0005 returns {8'hFF, register} on `rdata` in the same cycle. Every other case drives `rdata` to 16'h0000.
- R4: An address is global when register bit 7 is 1 and every bit set in the register is also set in address bits 15:8. Legal value 8'h80 gives the window 8000–FFFF, and 8'hFF gives FF00–FFFF. In each case the window starts at the register value times 256.
- R5: When register bit 7 is 0, no address is global, whatever the register's low bits hold. This covers, for example, the values 8'h03 and 8'h7F.
- R6: `breq_n` is 0 exactly in the cycles where `strb` is 1 and the address is global.
- R7: During a global access, `stall` is 1 in every cycle where `ready` is 0, and 0 in the cycle where `ready` is 1. In the cycle after ready is sampled, the strobe is dropped and `breq_n` returns to 1.
- R8: A local access keeps `stall` at 0 and `breq_n` at 1, whatever level `ready` has.
- R9: A write to any address other than 5, and a write to address 5 with `strb` at 0, both leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Data access address |
| strb | input | 1 | Data access strobe, active high |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 16 | Write data (the low byte feeds the register) |
| ready | input | 1 | Arbiter grant / global cycle completion |
| rdata | output | 16 | Register read data |
| breq_n | output | 1 | Active-low global bus request |
| stall | output | 1 | Holds the processor while a global access waits |

## Verification
The decode, request, stall and read data all follow the inputs combinationally within the same cycle. The bench therefore drives each stimulus just after a falling edge and samples these outputs 1 ns later, still before the next rising edge. A register write takes effect at the next rising edge. The bench model updates its copy of the register only after that cycle's checks, so the new value is expected from the following cycle on. For the release of the request, the bench samples `breq_n` one cycle after the cycle in which ready was high.

// File: rtl/gwin_pkg.sv
// Package gwin_pkg
// Shared widths and the register location for the global window decoder.
// Assumes a 16-bit word-addressed data space.
package gwin_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 16;
    localparam int WIN_W    = 8;
    localparam logic [ADDR_W-1:0] WIN_REG_ADDR = 16'h0005;

    // Classification of the current data access.
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_LOCAL  = 2'd1,
        ACC_GLOBAL = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/gwin_alloc_reg.sv
// Module gwin_alloc_reg
// Holds the window size register. Decodes strobed reads and writes of the
// register address. A write loads the low WIN_W bits of the write data, and
// a read returns the register with all unused upper bits set to one.
// Assumes the processor holds addr/strb/wr stable for the whole cycle.
module gwin_alloc_reg #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int WIN_W  = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0005
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strb,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [WIN_W-1:0]  win_mask,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - WIN_W;

    logic sel;
    logic wr_en;
    logic rd_en;

    // Select the register when the strobed address matches.
    always_comb begin
        sel   = strb && (addr == REG_ADDR);
        wr_en = sel && wr;
        rd_en = sel && !wr;
    end

    // Load or clear the window register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_mask <= '0;
        else if (wr_en)
            win_mask <= wdata[WIN_W-1:0];
    end

    // Drive read data; the unused upper bits read as ones.
    always_comb begin
        if (rd_en)
            rdata = {{PAD_W{1'b1}}, win_mask};
        else
            rdata = '0;
    end

    // R2: a strobed write to the register address is visible the next cycle.
    property p_reg_load_r2;
        @(posedge clk) disable iff (!rst_n)
        wr_en |=> (win_mask == $past(wdata[WIN_W-1:0]));
    endproperty
    a_reg_load_r2: assert property (p_reg_load_r2);

    // R9: without a register write, the value is kept.
    property p_reg_hold_r9;
        @(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(win_mask);
    endproperty
    a_reg_hold_r9: assert property (p_reg_hold_r9);

    // R1: reset clears the register.
    property p_reg_reset_r1;
        @(posedge clk) !rst_n |=> (win_mask == '0);
    endproperty
    a_reg_reset_r1: assert property (p_reg_reset_r1);
endmodule

// File: rtl/gwin_match.sv
// Module gwin_match
// Compares the address high byte against the window mask. An address is
// global when the mask's top bit is set and every set mask bit is also set
// in the address. Built as one AND term per mask bit.
// Assumes ADDR_W >= WIN_W.
module gwin_match #(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIN_W-1:0]  win_mask,
    output logic              hit
);
    localparam int HI_LSB = ADDR_W - WIN_W;

    logic [WIN_W-1:0] bit_ok;

    // One covering term per mask bit.
    for (genvar i = 0; i < WIN_W; i++) begin : g_cover
        assign bit_ok[i] = !win_mask[i] || addr[HI_LSB + i];
    end

    // The window is open only when the top mask bit is set.
    always_comb begin
        hit = win_mask[WIN_W-1] && (&bit_ok);
    end
endmodule

// File: rtl/gwin_handshake.sv
// Module gwin_handshake
// Drives the active-low bus request and the stall for global accesses.
// The request follows the strobe of a global access. The stall holds the
// processor until ready is seen. Tracks whether a wait is in progress.
// Assumes the processor keeps addr/strb stable while stall is high.
module gwin_handshake (
    input  logic clk,
    input  logic rst_n,
    input  logic strb,
    input  logic hit,
    input  logic ready,
    output logic breq_n,
    output logic stall,
    output logic waiting
);
    logic glob;

    // Request and stall from the current global strobe.
    always_comb begin
        glob   = strb && hit;
        breq_n = !glob;
        stall  = glob && !ready;
    end

    // Remember whether the previous cycle ended in a wait.
    always_ff @(posedge clk) begin
        if (!rst_n)
            waiting <= 1'b0;
        else
            waiting <= stall;
    end

    // R7: a stalled cycle always carries the request.
    property p_stall_req_r7;
        @(posedge clk) disable iff (!rst_n)
        stall |-> !breq_n;
    endproperty
    a_stall_req_r7: assert property (p_stall_req_r7);

    // R6: no request without a strobe.
    property p_req_strobe_r6;
        @(posedge clk) disable iff (!rst_n)
        !strb |-> breq_n;
    endproperty
    a_req_strobe_r6: assert property (p_req_strobe_r6);
endmodule

// File: rtl/gwin_decoder.sv
// Module gwin_decoder
// Top level of the global memory window decoder: the window register, the
// address comparator and the request/stall handshake.
// Assumes a single processor master. Arbitration and the shared memory
// itself are outside this block.
module gwin_decoder
    import gwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strb,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              breq_n,
    output logic              stall
);
    logic [WIN_W-1:0] win_mask;
    logic             hit;
    logic             waiting;
    acc_kind_e        kind;

    gwin_alloc_reg #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .WIN_W   (WIN_W),
        .REG_ADDR(WIN_REG_ADDR)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .strb    (strb),
        .wr      (wr),
        .wdata   (wdata),
        .win_mask(win_mask),
        .rdata   (rdata)
    );

    gwin_match #(
        .ADDR_W(ADDR_W),
        .WIN_W (WIN_W)
    ) u_match (
        .addr    (addr),
        .win_mask(win_mask),
        .hit     (hit)
    );

    gwin_handshake u_hs (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb   (strb),
        .hit    (hit),
        .ready  (ready),
        .breq_n (breq_n),
        .stall  (stall),
        .waiting(waiting)
    );

    // Classify the access for the checks below.
    always_comb begin
        if (!strb)
            kind = ACC_NONE;
        else if (hit)
            kind = ACC_GLOBAL;
        else
            kind = ACC_LOCAL;
    end

    // R8: local accesses never request the bus or stall.
    property p_local_free_r8;
        @(posedge clk) disable iff (!rst_n)
        (kind == ACC_LOCAL) |-> (breq_n && !stall);
    endproperty
    a_local_free_r8: assert property (p_local_free_r8);

    // R5: with the window closed, nothing is global.
    property p_closed_r5;
        @(posedge clk) disable iff (!rst_n)
        !win_mask[WIN_W-1] |-> breq_n;
    endproperty
    a_closed_r5: assert property (p_closed_r5);

    // R7: a wait that sees ready with the same access ends the stall.
    property p_wait_ends_r7;
        @(posedge clk) disable iff (!rst_n)
        (waiting && ready) |-> !stall;
    endproperty
    a_wait_ends_r7: assert property (p_wait_ends_r7);
endmodule

// File: tb/sim_gwin_decoder.sv
module sim_gwin_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        strb = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic        ready = 1'b0;
    logic [15:0] rdata;
    logic        breq_n;
    logic        stall;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] m_reg = 8'h00;

    gwin_decoder u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .strb(strb), .wr(wr),
        .wdata(wdata), .ready(ready), .rdata(rdata), .breq_n(breq_n), .stall(stall)
    );

    always #5 clk = ~clk;

    function automatic logic is_glob(input logic [15:0] a, input logic [7:0] g);
        return g[7] && ((a[15:8] & g) == g);
    endfunction

    function automatic logic [15:0] exp_rd(input logic [15:0] a, input logic s,
                                           input logic w, input logic [7:0] g);
        return (s && !w && a == 16'h0005) ? {8'hFF, g} : 16'h0000;
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one access after a falling edge; outputs settle 1 ns later.
    task automatic drive(input logic [15:0] a, input logic s, input logic w,
                         input logic [15:0] d, input logic r);
        @(negedge clk);
        addr = a; strb = s; wr = w; wdata = d; ready = r;
        #1;
    endtask

    // Check all outputs against the model; then update the model for the edge.
    task automatic check_all(input string tag);
        logic g;
        g = strb && is_glob(addr, m_reg);
        chk(rdata, exp_rd(addr, strb, wr, m_reg), {tag, " rdata"});
        chk({15'd0, breq_n}, {15'd0, !g}, {tag, " breq_n"});
        chk({15'd0, stall}, {15'd0, g && !ready}, {tag, " stall"});
        if (strb && wr && addr == 16'h0005) m_reg = wdata[7:0];
    endtask

    task automatic write_reg(input logic [7:0] v);
        drive(16'h0005, 1'b1, 1'b1, {8'hA5, v}, 1'b0);
        check_all("R2 write");
    endtask

    initial begin : watchdog
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        logic [15:0] base;
        repeat (3) @(negedge clk);
        drive(16'hFFFF, 1'b1, 1'b0, 16'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: after reset the register reads zero and nothing is global.
        drive(16'h0005, 1'b1, 1'b0, 16'h0, 1'b0);
        chk(rdata, 16'hFF00, "R1 reset read / R3 upper ones");
        drive(16'hFFFF, 1'b1, 1'b0, 16'h0, 1'b0);
        chk({15'd0, breq_n}, 16'd1, "R1 reset no request");
        chk({15'd0, stall}, 16'd0, "R1 reset no stall");

        // R4: every legal window value, at its edges.
        for (int k = 1; k <= 8; k++) begin
            v = 8'hFF << (8 - k);
            base = {v, 8'h00};
            write_reg(v);
            drive(16'h0005, 1'b1, 1'b0, 16'h0, 1'b0);
            chk(rdata, {8'hFF, v}, "R3 readback");
            drive(base - 16'd1, 1'b1, 1'b0, 16'h0, 1'b1);
            chk({15'd0, breq_n}, 16'd1, "R4 below window local");
            drive(base, 1'b1, 1'b0, 16'h0, 1'b1);
            chk({15'd0, breq_n}, 16'd0, "R4 window base global");
            drive(16'hFFFF, 1'b1, 1'b1, 16'h0, 1'b1);
            chk({15'd0, breq_n}, 16'd0, "R4 top global");
        end

        // R5: closed window values.
        write_reg(8'h03);
        drive(16'hFFFF, 1'b1, 1'b0, 16'h0, 1'b0);
        chk({15'd0, breq_n}, 16'd1, "R5 value 03 closed");
        write_reg(8'h7F);
        drive(16'hFFFF, 1'b1, 1'b0, 16'h0, 1'b0);
        chk({15'd0, breq_n}, 16'd1, "R5 value 7F closed");

        // R7: a global wait of three cycles, then ready, then release.
        write_reg(8'hE0);
        for (int i = 0; i < 3; i++) begin
            drive(16'hE123, 1'b1, 1'b0, 16'h0, 1'b0);
            chk({15'd0, stall}, 16'd1, "R7 stall while not ready");
            chk({15'd0, breq_n}, 16'd0, "R6 request held in wait");
        end
        drive(16'hE123, 1'b1, 1'b0, 16'h0, 1'b1);
        chk({15'd0, stall}, 16'd0, "R7 stall drops with ready");
        drive(16'hE123, 1'b0, 1'b0, 16'h0, 1'b0);
        chk({15'd0, breq_n}, 16'd1, "R7 request released after ready");

        // R8: a local access ignores ready.
        drive(16'h1234, 1'b1, 1'b0, 16'h0, 1'b0);
        chk({15'd0, stall}, 16'd0, "R8 local no stall");
        chk({15'd0, breq_n}, 16'd1, "R8 local no request");

        // R9: writes that must not touch the register.
        drive(16'h0006, 1'b1, 1'b1, 16'h00FF, 1'b0);
        drive(16'h0005, 1'b0, 1'b1, 16'h0011, 1'b0);
        drive(16'h0005, 1'b1, 1'b0, 16'h0, 1'b0);
        chk(rdata, 16'hFFE0, "R9 register unchanged");
        drive(16'h0004, 1'b1, 1'b0, 16'h0, 1'b0);
        chk(rdata, 16'h0000, "R3 other read zero");

        // Random mix with a fixed seed.
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic [15:0] d;
            int sel;
            sel = $urandom_range(0, 7);
            if (sel == 0) a = 16'h0005;
            else if (sel < 4) a = {8'hFF << $urandom_range(0, 8), 8'($urandom)};
            else a = 16'($urandom);
            d = (($urandom_range(0, 3)) == 0) ? 16'($urandom)
                                               : {8'h00, 8'hFF << $urandom_range(0, 8)};
            drive(a, 1'($urandom), 1'($urandom), d, 1'($urandom));
            check_all("R4 R6 R3 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule